// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block watches the stream of memory accesses seen by a cache. Each access carries an address, the program counter of the instruction that made it, a requester ID, and flags for miss/hit, read/write and instruction/data. For each instruction it learns the distance between successive addresses, called the stride. It keeps this history in a small set-associative table indexed by the PC.

Each tracked instruction has a saturating confidence counter. When the counter is high enough and the observed stride is non-zero, the block emits a short burst of prefetch addresses ahead of the current access, one per cycle, toward a downstream queue. Configuration inputs choose which accesses may train the table. A further option keeps separate histories per requester for the same PC.

Top module: `stride_pf`

## Requirements
- R1: After reset, and while the table is empty, `pf_valid_o` is 0.
- R2: The first training access of a PC/requester key allocates an entry with confidence 4 and stride 0 and emits nothing. Each later training access for the key computes stride = address - last address.
- R3: Confidence moves up by 1 when the new stride equals the stored stride and saturates at 7. Otherwise it moves down by 1 and saturates at 0, and the stored stride is replaced by the new one.
- R4: A training access emits a burst only when the updated confidence is at least 4.
- R5: A burst carries 4 addresses: address + k*stride for k = 1, 2, 3, 4, in that order, with wrap-around modulo 2^32. They appear on consecutive cycles, starting the cycle after the access. `pf_valid_o` falls after the 4th address.
- R6: A new burst triggered while one is in progress replaces it. The next cycle already shows the new burst's first address.
- R7: An access trains only if it passes every enabled filter. With `cfg_miss_only_i`=1 it must be a miss. A read (`acc_write_i`=0) needs `cfg_read_en_i`, and a write needs `cfg_write_en_i`. A data access (`acc_inst_i`=0) needs `cfg_data_en_i`, and an instruction access needs `cfg_inst_en_i`. A filtered access changes no state and emits nothing.
- R8: With `cfg_rid_split_i`=1 the requester ID is part of the entry key, so requesters sharing a PC train separately. With 0 they share one entry.
- R9: No burst is emitted when the new stride is 0, whatever the confidence.
- R10: The set is chosen by PC bits [3:0], giving 16 sets of 4 ways. On a miss, the way is picked by a per-set round-robin pointer that advances on each allocation. A fifth key in a full set evicts the oldest allocated entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_pc_i | input | 32 | PC of the accessing instruction |
| acc_rid_i | input | 4 | Requester ID |
| acc_miss_i | input | 1 | 1 = access missed the cache |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_inst_i | input | 1 | 1 = instruction fetch, 0 = data |
| cfg_miss_only_i | input | 1 | Train on misses only |
| cfg_read_en_i | input | 1 | Reads may train |
| cfg_write_en_i | input | 1 | Writes may train |
| cfg_data_en_i | input | 1 | Data accesses may train |
| cfg_inst_en_i | input | 1 | Instruction accesses may train |
| cfg_rid_split_i | input | 1 | Keep per-requester history |
| pf_valid_o | output | 1 | Prefetch address valid |
| pf_addr_o | output | 32 | Prefetch address |

## Verification
The main function is tried with several kinds of sequence:
- A steady positive stride and a wrapping negative stride show when a burst starts and check its address arithmetic.
- A repeated address shows that a zero stride is suppressed even at high confidence.
- A long alternating-stride run after saturation tells a bounded counter from an unbounded one at both ends. Exactly three bursts follow the first mismatch at the top, and four matches are needed to climb back from zero.
- Patterns where a filtered access sits between valid ones give different emissions depending on whether the filtered access trained.
- Interleaved requesters on one PC, and five keys in one set, separate keyed from shared history and show which entry round-robin eviction removes.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  // saturating step of a confidence counter
  function automatic int unsigned conf_step(int unsigned c, bit up, int unsigned maxv);
    if (up) return (c >= maxv) ? maxv : c + 1;
    else    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int unsigned safe_log2(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/stride_pf_filter.sv
module stride_pf_filter (
  input  logic acc_valid_i,
  input  logic acc_miss_i,
  input  logic acc_write_i,
  input  logic acc_inst_i,
  input  logic cfg_miss_only_i,
  input  logic cfg_read_en_i,
  input  logic cfg_write_en_i,
  input  logic cfg_data_en_i,
  input  logic cfg_inst_en_i,
  output logic train_o
);
  logic miss_ok, dir_ok, kind_ok;

  always_comb begin
    miss_ok = !cfg_miss_only_i || acc_miss_i;
    dir_ok  = acc_write_i ? cfg_write_en_i : cfg_read_en_i;
    kind_ok = acc_inst_i  ? cfg_inst_en_i  : cfg_data_en_i;
    train_o = acc_valid_i && miss_ok && dir_ok && kind_ok;
  end
endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned RID_W       = 4,
  parameter int unsigned SETS        = 16,
  parameter int unsigned WAYS        = 4,
  parameter int unsigned CONF_MAX    = 7,
  parameter int unsigned CONF_START  = 4,
  parameter int unsigned CONF_THRESH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              train_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [RID_W-1:0]  rid_i,
  input  logic              rid_split_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] stride_o
);
  localparam int unsigned IDX_W  = safe_log2(SETS);
  localparam int unsigned WAY_W  = safe_log2(WAYS);
  localparam int unsigned TAG_W  = PC_W + RID_W;
  localparam int unsigned CONF_W = safe_log2(CONF_MAX + 1);

  logic              valid_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q    [SETS][WAYS];
  logic [ADDR_W-1:0] last_q   [SETS][WAYS];
  logic [ADDR_W-1:0] stride_q [SETS][WAYS];
  logic [CONF_W-1:0] conf_q   [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q     [SETS];

  logic [RID_W-1:0]  rid_eff;
  logic [TAG_W-1:0]  key;
  logic [IDX_W-1:0]  idx;
  logic [WAYS-1:0]   hit_vec;
  logic              hit_any;
  logic [WAY_W-1:0]  hit_way;
  logic [ADDR_W-1:0] new_stride;
  logic              same_stride;
  logic [CONF_W-1:0] conf_nxt;

  assign rid_eff = rid_split_i ? rid_i : '0;
  assign key     = {rid_eff, pc_i};
  assign idx     = IDX_W'(pc_i % SETS);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == key);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w] && !hit_any) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    new_stride  = addr_i - last_q[idx][hit_way];
    same_stride = (new_stride == stride_q[idx][hit_way]);
    conf_nxt    = CONF_W'(conf_step(int'(conf_q[idx][hit_way]), same_stride, CONF_MAX));
    start_o     = train_i && hit_any && (conf_nxt >= CONF_W'(CONF_THRESH)) &&
                  (new_stride != '0);
    stride_o    = new_stride;
  end

  // valid bits and replacement pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) valid_q[s][w] <= 1'b0;
      end
    end else if (train_i && !hit_any) begin
      valid_q[idx][rr_q[idx]] <= 1'b1;
      rr_q[idx] <= (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
    end
  end

  // entry payload
  always_ff @(posedge clk_i) begin
    if (train_i) begin
      if (hit_any) begin
        last_q[idx][hit_way]   <= addr_i;
        stride_q[idx][hit_way] <= new_stride;
        conf_q[idx][hit_way]   <= conf_nxt;
      end else begin
        tag_q[idx][rr_q[idx]]    <= key;
        last_q[idx][rr_q[idx]]   <= addr_i;
        stride_q[idx][rr_q[idx]] <= '0;
        conf_q[idx][rr_q[idx]]   <= CONF_W'(CONF_START);
      end
    end
  end
endmodule

// File: rtl/stride_pf_burst.sv
module stride_pf_burst
  import stride_pf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEGREE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  localparam int unsigned CNT_W = safe_log2(DEGREE + 1);

  logic [ADDR_W-1:0] cur_q, step_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      step_q <= '0;
      left_q <= '0;
    end else if (start_i) begin
      cur_q  <= base_i + stride_i;
      step_q <= stride_i;
      left_q <= CNT_W'(DEGREE);
    end else if (left_q != '0) begin
      cur_q  <= cur_q + step_q;
      left_q <= left_q - 1'b1;
    end
  end

  assign pf_valid_o = (left_q != '0);
  assign pf_addr_o  = cur_q;
endmodule

// File: rtl/stride_pf.sv
module stride_pf #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned RID_W       = 4,
  parameter int unsigned SETS        = 16,
  parameter int unsigned WAYS        = 4,
  parameter int unsigned CONF_MAX    = 7,
  parameter int unsigned CONF_START  = 4,
  parameter int unsigned CONF_THRESH = 4,
  parameter int unsigned DEGREE      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic [RID_W-1:0]  acc_rid_i,
  input  logic              acc_miss_i,
  input  logic              acc_write_i,
  input  logic              acc_inst_i,
  input  logic              cfg_miss_only_i,
  input  logic              cfg_read_en_i,
  input  logic              cfg_write_en_i,
  input  logic              cfg_data_en_i,
  input  logic              cfg_inst_en_i,
  input  logic              cfg_rid_split_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic              train;
  logic              pf_start;
  logic [ADDR_W-1:0] pf_stride;

  stride_pf_filter u_filter (
    .acc_valid_i     (acc_valid_i),
    .acc_miss_i      (acc_miss_i),
    .acc_write_i     (acc_write_i),
    .acc_inst_i      (acc_inst_i),
    .cfg_miss_only_i (cfg_miss_only_i),
    .cfg_read_en_i   (cfg_read_en_i),
    .cfg_write_en_i  (cfg_write_en_i),
    .cfg_data_en_i   (cfg_data_en_i),
    .cfg_inst_en_i   (cfg_inst_en_i),
    .train_o         (train)
  );

  stride_pf_table #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .RID_W(RID_W), .SETS(SETS), .WAYS(WAYS),
    .CONF_MAX(CONF_MAX), .CONF_START(CONF_START), .CONF_THRESH(CONF_THRESH)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .train_i     (train),
    .addr_i      (acc_addr_i),
    .pc_i        (acc_pc_i),
    .rid_i       (acc_rid_i),
    .rid_split_i (cfg_rid_split_i),
    .start_o     (pf_start),
    .stride_o    (pf_stride)
  );

  stride_pf_burst #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (pf_start),
    .base_i     (acc_addr_i),
    .stride_i   (pf_stride),
    .pf_valid_o (pf_valid_o),
    .pf_addr_o  (pf_addr_o)
  );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEGREE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_miss_i,
  input logic              cfg_miss_only_i,
  input logic              train_i,
  input logic              start_i,
  input logic [ADDR_W-1:0] stride_i,
  input logic              pf_valid_o,
  input logic [ADDR_W-1:0] pf_addr_o
);
  int unsigned since_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         since_start <= DEGREE;
    else if (start_i)    since_start <= 0;
    else if (pf_valid_o) since_start <= since_start + 1;
  end

  p_first_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pf_valid_o && (pf_addr_o == $past(acc_addr_i) + $past(stride_i)));

  p_burst_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> since_start < DEGREE);

  p_zero_stride_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> stride_i != '0);

  p_needs_train_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> train_i && acc_valid_i);

  p_miss_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && cfg_miss_only_i && !acc_miss_i) |-> !start_i);

  p_idle_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pf_valid_o);
endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .acc_valid_i     (acc_valid_i),
  .acc_addr_i      (acc_addr_i),
  .acc_miss_i      (acc_miss_i),
  .cfg_miss_only_i (cfg_miss_only_i),
  .train_i         (train),
  .start_i         (pf_start),
  .stride_i        (pf_stride),
  .pf_valid_o      (pf_valid_o),
  .pf_addr_o       (pf_addr_o)
);

// File: tb/stride_pf_bench.sv
module stride_pf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [31:0] acc_pc_i = '0;
  logic [3:0]  acc_rid_i = '0;
  logic        acc_miss_i = 1'b0, acc_write_i = 1'b0, acc_inst_i = 1'b0;
  logic        cfg_miss_only_i = 1'b0, cfg_read_en_i = 1'b1, cfg_write_en_i = 1'b1;
  logic        cfg_data_en_i = 1'b1, cfg_inst_en_i = 1'b1, cfg_rid_split_i = 1'b1;
  logic        pf_valid_o;
  logic [31:0] pf_addr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // single-entry model
  bit          m_valid;
  logic [31:0] m_last, m_st;
  int          m_conf;

  always #4 clk_i = ~clk_i;

  stride_pf u_stride_pf (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic defaults();
    cfg_miss_only_i = 0; cfg_read_en_i = 1; cfg_write_en_i = 1;
    cfg_data_en_i = 1; cfg_inst_en_i = 1; cfg_rid_split_i = 1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_valid = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!pf_valid_o, "R1 idle after reset", 32'(pf_valid_o), 0);
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] pc, logic [3:0] rid,
                       bit miss, bit wr, bit inst);
    acc_addr_i = a; acc_pc_i = pc; acc_rid_i = rid;
    acc_miss_i = miss; acc_write_i = wr; acc_inst_i = inst;
    acc_valid_i = 1'b1;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  task automatic chk_burst(logic [31:0] base, logic [31:0] st, string req);
    for (int k = 1; k <= 4; k++) begin
      chk(pf_valid_o, req, 32'(pf_valid_o), 1);
      chk(pf_addr_o == base + st * 32'(k), req, pf_addr_o, base + st * 32'(k));
      @(negedge clk_i);
    end
    chk(!pf_valid_o, req, 32'(pf_valid_o), 0);
  endtask

  task automatic chk_none(string req);
    chk(!pf_valid_o, req, 32'(pf_valid_o), 0);
    @(negedge clk_i);
    chk(!pf_valid_o, req, 32'(pf_valid_o), 0);
  endtask

  // drive one access and compare with the single-entry model
  task automatic step(logic [31:0] a, logic [31:0] pc, string req);
    logic [31:0] s;
    bit emit;
    drive(a, pc, 4'd0, 1, 0, 0);
    if (!m_valid) begin
      m_valid = 1; m_st = 0; m_conf = 4; emit = 0; s = 0;
    end else begin
      s = a - m_last;
      if (s == m_st) m_conf = (m_conf == 7) ? 7 : m_conf + 1;
      else begin
        m_conf = (m_conf == 0) ? 0 : m_conf - 1;
        m_st = s;
      end
      emit = (m_conf >= 4) && (s != 0);
    end
    m_last = a;
    if (emit) chk_burst(a, s, req);
    else      chk_none(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    @(negedge clk_i);
    defaults();
    do_reset();

    // R2 / R4: allocate, first stride, then first confident burst
    step(32'h1000, 32'h40, "R2 alloc");
    step(32'h1010, 32'h40, "R2 first stride");
    step(32'h1020, 32'h40, "R4 threshold");
    step(32'h1030, 32'h40, "R5 steady");

    // R5: negative stride wraps
    do_reset();
    step(32'h2000, 32'h88, "R5 neg");
    step(32'h1ff0, 32'h88, "R5 neg");
    step(32'h1fe0, 32'h88, "R5 neg");
    step(32'h1fd0, 32'h88, "R5 neg");

    // R9: zero stride never emits
    do_reset();
    for (int i = 0; i < 6; i++) step(32'h3000, 32'h9c, "R9 zero stride");

    // R3: saturation at both ends
    do_reset();
    a = 32'h4000;
    step(a, 32'h7, "R3 up");
    for (int i = 0; i < 8; i++) begin a += 8; step(a, 32'h7, "R3 up"); end
    for (int i = 0; i < 14; i++) begin
      a += (i % 2) ? 32'd5 : 32'd3;
      step(a, 32'h7, "R3 down");
    end
    for (int i = 0; i < 6; i++) begin a += 3; step(a, 32'h7, "R3 floor"); end

    // R6: new burst replaces running one
    do_reset();
    drive(32'h10000, 32'h100, 0, 1, 0, 0); chk_none("R6 setup");
    drive(32'h20000, 32'h204, 0, 1, 0, 0); chk_none("R6 setup");
    drive(32'h10040, 32'h100, 0, 1, 0, 0); chk_none("R6 setup");
    drive(32'h20100, 32'h204, 0, 1, 0, 0); chk_none("R6 setup");
    drive(32'h10080, 32'h100, 0, 1, 0, 0);
    chk(pf_valid_o && pf_addr_o == 32'h100c0, "R6 first burst", pf_addr_o, 32'h100c0);
    drive(32'h20200, 32'h204, 0, 1, 0, 0);
    chk_burst(32'h20200, 32'h100, "R6 restart");

    // R7: filtered access in the middle must not train
    for (int c = 0; c < 5; c++) begin
      bit gm, gw, gi, bm, bw, bi;
      logic [31:0] b;
      defaults();
      do_reset();
      gm = 1; gw = 0; gi = 0; bm = 1; bw = 0; bi = 0;
      case (c)
        0: begin cfg_miss_only_i = 1; bm = 0; end
        1: begin cfg_read_en_i = 0; gw = 1; end
        2: begin cfg_write_en_i = 0; bw = 1; end
        3: begin cfg_inst_en_i = 0; bi = 1; end
        default: begin cfg_data_en_i = 0; gi = 1; end
      endcase
      b = 32'h50000 + 32'(c) * 32'h10000;
      drive(b, 32'h60, 0, gm, gw, gi);            chk_none("R7 filter");
      drive(b + 32'h50, 32'h60, 0, bm, bw, bi);   chk_none("R7 filter");
      drive(b + 32'h100, 32'h60, 0, gm, gw, gi);  chk_none("R7 filter");
      drive(b + 32'h200, 32'h60, 0, gm, gw, gi);
      chk_burst(b + 32'h200, 32'h100, "R7 filter");
    end
    defaults();

    // R8: per-requester history
    do_reset();
    drive(32'h1000, 32'h70, 1, 1, 0, 0); chk_none("R8 split");
    drive(32'h5000, 32'h70, 2, 1, 0, 0); chk_none("R8 split");
    drive(32'h1010, 32'h70, 1, 1, 0, 0); chk_none("R8 split");
    drive(32'h5100, 32'h70, 2, 1, 0, 0); chk_none("R8 split");
    drive(32'h1020, 32'h70, 1, 1, 0, 0); chk_burst(32'h1020, 32'h10, "R8 split");
    drive(32'h5200, 32'h70, 2, 1, 0, 0); chk_burst(32'h5200, 32'h100, "R8 split");
    cfg_rid_split_i = 0;
    do_reset();
    drive(32'h1000, 32'h70, 1, 1, 0, 0); chk_none("R8 shared");
    drive(32'h5000, 32'h70, 2, 1, 0, 0); chk_none("R8 shared");
    drive(32'h1010, 32'h70, 1, 1, 0, 0); chk_none("R8 shared");
    drive(32'h5100, 32'h70, 2, 1, 0, 0); chk_none("R8 shared");
    drive(32'h1020, 32'h70, 1, 1, 0, 0); chk_none("R8 shared");
    drive(32'h5200, 32'h70, 2, 1, 0, 0); chk_none("R8 shared");
    defaults();

    // R10: five keys in set 3, round-robin eviction
    do_reset();
    for (int p = 0; p < 5; p++) begin
      drive(32'(p) * 32'h1000, 32'h3 + 32'(p) * 32'h10, 0, 1, 0, 0);
      chk_none("R10 fill");
      drive(32'(p) * 32'h1000 + 4, 32'h3 + 32'(p) * 32'h10, 0, 1, 0, 0);
      chk_none("R10 fill");
    end
    drive(32'h2008, 32'h23, 0, 1, 0, 0); chk_burst(32'h2008, 4, "R10 kept");
    drive(32'h0008, 32'h03, 0, 1, 0, 0); chk_none("R10 evicted");
    drive(32'h4008, 32'h43, 0, 1, 0, 0); chk_burst(32'h4008, 4, "R10 newest");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule